// File: doc/BRIEF.md
# Counting Frequency Match Detector

This block judges whether two pulse streams run at the same rate. One stream is a reference and the other is a feedback stream from an oscillator loop. Each arrives as single-cycle strobes already aligned to one system clock. Each stream first passes through its own programmable integer pre-divider. The divided streams are then counted over a measurement window. The window closes on the divided reference pulse that brings the reference count up to a programmable length.

On that closing cycle the block forms a signed difference: the feedback count, minus the window length, plus a programmable signed bias. One cycle later it presents that difference on a held output. In the same cycle it raises a match strobe if the magnitude lies below a programmable tolerance. It raises a loss strobe if the magnitude is greater than 1/200 of the window length, which is 5000 ppm. A frequency-tracking loop reads the difference as its error term. Lock supervision logic reads the two strobes.

Top module: `freq_match_detector`

## Requirements
- R1: While reset is asserted, and until the first window has closed, match_o and loss_o are 0 and diff_o is 0.
- R2: The reference pre-divider passes every ref_div_i-th pulse of ref_pulse_i, the first one counted being the ref_div_i-th after reset. A setting of 0 behaves as 1, and 0 or 1 passes every pulse.
- R3: The feedback pre-divider acts in the same way on fb_pulse_i, using fb_div_i.
- R4: A window closes in the cycle that carries the divided reference pulse bringing the reference count to win_max_i. A win_max_i of 0 acts as 1. The results of that window appear on the outputs in the following cycle.
- R5: diff_o is a two's-complement value of CNT_W+3 bits. It equals the number of divided feedback pulses in the window, plus cnt_offset_i read as a signed CNT_W-bit value, minus the window length. The pulse count includes a feedback pulse in the closing cycle. diff_o holds its value until the next window result.
- R6: match_o is high for one cycle after a window whose difference magnitude is strictly less than match_tol_i. A magnitude equal to the tolerance gives no match.
- R7: loss_o is high for one cycle after a window whose difference magnitude, multiplied by 200, is strictly greater than the window length.
- R8: Both window counts clear after the closing cycle. Pulses in the closing cycle belong to the window that is ending, and the next window counts from zero.
- R9: match_o and loss_o are 0 in every cycle that does not directly follow a window closing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_pulse_i | input | 1 | Reference stream strobe, one cycle per pulse |
| fb_pulse_i | input | 1 | Feedback stream strobe, one cycle per pulse |
| ref_div_i | input | DIV_W | Reference pre-divide ratio (0 acts as 1) |
| fb_div_i | input | DIV_W | Feedback pre-divide ratio (0 acts as 1) |
| win_max_i | input | CNT_W | Window length in divided reference pulses (0 acts as 1) |
| cnt_offset_i | input | CNT_W | Signed bias added to the count difference |
| match_tol_i | input | CNT_W | Match tolerance; a match needs a magnitude below this value |
| match_o | output | 1 | One-cycle strobe: the window matched |
| loss_o | output | 1 | One-cycle strobe: the window error is above 5000 ppm |
| diff_o | output | CNT_W+3 | Signed count difference of the latest window, held |

## Verification
The first stimulus uses equal periodic rates with no bias. It shows that a clean match gives a zero difference and no loss strobe. A second pattern reaches equal rates only through unequal pre-divide settings, one of them 0. It separates correct divider wrap and zero handling from a divider that is merely bypassed.

A feedback stream twice as fast as the reference, and a run whose magnitude sits exactly on the tolerance, test the strict comparisons on both strobes. A window length of 0 with a negative bias tests one-pulse windows and the sign handling. A pseudo-random pulse pattern produces pulses on closing cycles. It shows whether those pulses are assigned to the ending window or the next one.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  // 5000 ppm expressed as a ratio of 1/200
  localparam int unsigned FMD_LOSS_DEN = 200;

  // window verdict, produced on the closing cycle
  typedef struct packed {
    logic near;
    logic far;
  } fmd_verdict_t;
endpackage

// File: rtl/fmd_prescaler.sv
module fmd_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] last_idx;
  logic             wrap;
  logic             cnt_en;

  always_comb begin
    last_idx = (div_i == '0) ? '0 : div_i - 1'b1;
    wrap     = (cnt_q >= last_idx);
    cnt_en   = pulse_i;
    cnt_d    = wrap ? '0 : cnt_q + 1'b1;
    tick_o   = pulse_i && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fmd_window_counter.sv
module fmd_window_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick_i,
  input  logic             fb_tick_i,
  input  logic [CNT_W-1:0] win_max_i,
  output logic             win_end_o,
  output logic [CNT_W:0]   fb_total_o,
  output logic [CNT_W-1:0] win_len_o
);
  logic [CNT_W-1:0] ref_cnt_q, ref_cnt_d;
  logic [CNT_W:0]   fb_cnt_q, fb_cnt_d;
  logic [CNT_W:0]   fb_sum;
  logic             cnt_en;

  always_comb begin
    win_len_o = (win_max_i == '0) ? CNT_W'(1) : win_max_i;
    win_end_o = ref_tick_i && (ref_cnt_q >= (win_len_o - 1'b1));
    // feedback count saturates rather than wrapping
    if (fb_tick_i && (fb_cnt_q != '1)) begin
      fb_sum = fb_cnt_q + 1'b1;
    end else begin
      fb_sum = fb_cnt_q;
    end
    fb_total_o = fb_sum;
    cnt_en     = ref_tick_i | fb_tick_i;
    if (win_end_o) begin
      ref_cnt_d = '0;
      fb_cnt_d  = '0;
    end else begin
      ref_cnt_d = ref_tick_i ? ref_cnt_q + 1'b1 : ref_cnt_q;
      fb_cnt_d  = fb_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      fb_cnt_q  <= '0;
    end else if (cnt_en) begin
      ref_cnt_q <= ref_cnt_d;
      fb_cnt_q  <= fb_cnt_d;
    end
  end
endmodule

// File: rtl/fmd_evaluator.sv
module fmd_evaluator
  import fmd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOSS_DEN = FMD_LOSS_DEN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_end_i,
  input  logic [CNT_W:0]          fb_total_i,
  input  logic [CNT_W-1:0]        win_len_i,
  input  logic [CNT_W-1:0]        offset_i,
  input  logic [CNT_W-1:0]        tol_i,
  output logic                    match_o,
  output logic                    loss_o,
  output logic signed [CNT_W+2:0] diff_o
);
  localparam int DIFF_W = CNT_W + 3;
  localparam int DEN_W  = $clog2(LOSS_DEN + 1);
  localparam int PROD_W = DIFF_W + DEN_W;

  logic signed [DIFF_W-1:0] fb_ext, len_ext, ofs_ext, diff_c;
  logic        [DIFF_W-1:0] mag_c, tol_ext;
  logic        [PROD_W-1:0] scaled_c;
  fmd_verdict_t             verdict;

  logic                     match_q, match_d;
  logic                     loss_q, loss_d;
  logic signed [DIFF_W-1:0] diff_q, diff_d;
  logic                     diff_en;

  always_comb begin
    fb_ext   = {{(DIFF_W-CNT_W-1){1'b0}}, fb_total_i};
    len_ext  = {{(DIFF_W-CNT_W){1'b0}}, win_len_i};
    ofs_ext  = {{(DIFF_W-CNT_W){offset_i[CNT_W-1]}}, offset_i};
    diff_c   = fb_ext - len_ext + ofs_ext;
    mag_c    = diff_c[DIFF_W-1] ? -diff_c : diff_c;
    tol_ext  = {{(DIFF_W-CNT_W){1'b0}}, tol_i};
    scaled_c = PROD_W'(mag_c) * PROD_W'(LOSS_DEN);
    verdict.near = (mag_c < tol_ext);
    verdict.far  = (scaled_c > PROD_W'(win_len_i));
  end

  always_comb begin
    match_d = win_end_i && verdict.near;
    loss_d  = win_end_i && verdict.far;
    diff_en = win_end_i;
    diff_d  = diff_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      loss_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      loss_q  <= loss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
    end else if (diff_en) begin
      diff_q <= diff_d;
    end
  end

  assign match_o = match_q;
  assign loss_o  = loss_q;
  assign diff_o  = diff_q;
endmodule

// File: rtl/freq_match_detector.sv
module freq_match_detector
  import fmd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 16,
  parameter int LOSS_DEN = FMD_LOSS_DEN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_pulse_i,
  input  logic                    fb_pulse_i,
  input  logic [DIV_W-1:0]        ref_div_i,
  input  logic [DIV_W-1:0]        fb_div_i,
  input  logic [CNT_W-1:0]        win_max_i,
  input  logic [CNT_W-1:0]        cnt_offset_i,
  input  logic [CNT_W-1:0]        match_tol_i,
  output logic                    match_o,
  output logic                    loss_o,
  output logic signed [CNT_W+2:0] diff_o
);
  localparam int NSTREAM = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             pulse_v [NSTREAM];
  logic             tick_v  [NSTREAM];
  logic [DIV_W-1:0] div_v   [NSTREAM];
  logic             ref_tick, fb_tick;
  logic             win_end;
  logic [CNT_W:0]   fb_total;
  logic [CNT_W-1:0] win_len;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign pulse_v[0] = ref_pulse_i;
  assign pulse_v[1] = fb_pulse_i;
  assign div_v[0]   = ref_div_i;
  assign div_v[1]   = fb_div_i;

  for (genvar s = 0; s < NSTREAM; s++) begin : g_pre
    fmd_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .pulse_i(pulse_v[s]),
      .div_i  (div_v[s]),
      .tick_o (tick_v[s])
    );
  end

  assign ref_tick = tick_v[0];
  assign fb_tick  = tick_v[1];

  fmd_window_counter #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ref_tick_i(ref_tick),
    .fb_tick_i (fb_tick),
    .win_max_i (win_max_i),
    .win_end_o (win_end),
    .fb_total_o(fb_total),
    .win_len_o (win_len)
  );

  fmd_evaluator #(.CNT_W(CNT_W), .LOSS_DEN(LOSS_DEN)) u_eval (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .win_end_i (win_end),
    .fb_total_i(fb_total),
    .win_len_i (win_len),
    .offset_i  (cnt_offset_i),
    .tol_i     (match_tol_i),
    .match_o   (match_o),
    .loss_o    (loss_o),
    .diff_o    (diff_o)
  );
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_pulse_i,
  input logic                    fb_pulse_i,
  input logic [DIV_W-1:0]        ref_div_i,
  input logic                    ref_tick,
  input logic                    fb_tick,
  input logic                    win_end,
  input logic [CNT_W-1:0]        match_tol_i,
  input logic                    match_o,
  input logic                    loss_o,
  input logic signed [CNT_W+2:0] diff_o
);
  localparam int DIFF_W = CNT_W + 3;

  logic signed [DIFF_W:0] tol_s;
  assign tol_s = {{(DIFF_W-CNT_W+1){1'b0}}, match_tol_i};

  assert_ref_tick_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> ref_pulse_i);

  assert_ref_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse_i && (ref_div_i <= DIV_W'(1))) |-> ref_tick);

  assert_fb_tick_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |-> fb_pulse_i);

  assert_close_on_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> ref_tick);

  assert_diff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(diff_o));

  assert_match_in_tol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ((DIFF_W+1)'(diff_o) < tol_s) && ((DIFF_W+1)'(diff_o) > -tol_s));

  assert_strobe_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> (!match_o && !loss_o));
endmodule

bind freq_match_detector fmd_checker #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .ref_pulse_i(ref_pulse_i),
  .fb_pulse_i (fb_pulse_i),
  .ref_div_i  (ref_div_i),
  .ref_tick   (ref_tick),
  .fb_tick    (fb_tick),
  .win_end    (win_end),
  .match_tol_i(match_tol_i),
  .match_o    (match_o),
  .loss_o     (loss_o),
  .diff_o     (diff_o)
);

// File: tb/freq_match_detector_bench.sv
module freq_match_detector_bench;
  localparam int DIV_W  = 8;
  localparam int CNT_W  = 16;
  localparam int DIFF_W = CNT_W + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                     rst_n;
  logic                     ref_pulse_i, fb_pulse_i;
  logic [DIV_W-1:0]         ref_div_i, fb_div_i;
  logic [CNT_W-1:0]         win_max_i, cnt_offset_i, match_tol_i;
  logic                     match_o, loss_o;
  logic signed [DIFF_W-1:0] diff_o;

  freq_match_detector u_freq_match_detector (
    .clk(clk), .rst_n(rst_n),
    .ref_pulse_i(ref_pulse_i), .fb_pulse_i(fb_pulse_i),
    .ref_div_i(ref_div_i), .fb_div_i(fb_div_i),
    .win_max_i(win_max_i), .cnt_offset_i(cnt_offset_i),
    .match_tol_i(match_tol_i),
    .match_o(match_o), .loss_o(loss_o), .diff_o(diff_o)
  );

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  int  cfg_rdiv, cfg_fdiv, cfg_wmax, cfg_ofs, cfg_tol;
  int  m_rpre, m_fpre, m_rcnt, m_fcnt;
  int  exp_diff;
  bit  exp_match, exp_loss;
  int  lfsr;

  task automatic compare(string tag);
    vectors++;
    if (match_o !== exp_match) begin
      miscompares++;
      $display("FAIL %s %s match_o act=%0b exp=%0b", tag, exp_match ? "R6" : "R9",
               match_o, exp_match);
    end
    if (loss_o !== exp_loss) begin
      miscompares++;
      $display("FAIL %s %s loss_o act=%0b exp=%0b", tag, exp_loss ? "R7" : "R9",
               loss_o, exp_loss);
    end
    if (int'(diff_o) !== exp_diff) begin
      miscompares++;
      $display("FAIL %s R5 diff_o act=%0d exp=%0d", tag, int'(diff_o), exp_diff);
    end
  endtask

  // advance the model by the edge that will sample the current inputs
  task automatic model_step(bit rp, bit fp);
    int  rlim, flim, wl, fbtot, mag;
    bit  rt, ft;
    rlim = (cfg_rdiv == 0) ? 1 : cfg_rdiv;
    flim = (cfg_fdiv == 0) ? 1 : cfg_fdiv;
    wl   = (cfg_wmax == 0) ? 1 : cfg_wmax;
    rt = 1'b0;
    ft = 1'b0;
    if (rp) begin
      if (m_rpre + 1 >= rlim) begin m_rpre = 0; rt = 1'b1; end
      else m_rpre++;
    end
    if (fp) begin
      if (m_fpre + 1 >= flim) begin m_fpre = 0; ft = 1'b1; end
      else m_fpre++;
    end
    fbtot = m_fcnt + (ft ? 1 : 0);
    if (rt && (m_rcnt + 1 >= wl)) begin
      exp_diff  = fbtot - wl + cfg_ofs;
      mag       = (exp_diff < 0) ? -exp_diff : exp_diff;
      exp_match = (mag < cfg_tol);
      exp_loss  = (mag * 200 > wl);
      m_rcnt = 0;
      m_fcnt = 0;
    end else begin
      exp_match = 1'b0;
      exp_loss  = 1'b0;
      m_rcnt += rt ? 1 : 0;
      m_fcnt  = fbtot;
    end
  endtask

  task automatic start(int rdiv, int fdiv, int wmax, int ofs, int tol);
    @(negedge clk);
    rst_n       = 1'b0;
    ref_pulse_i = 1'b0;
    fb_pulse_i  = 1'b0;
    cfg_rdiv = rdiv; cfg_fdiv = fdiv; cfg_wmax = wmax; cfg_ofs = ofs; cfg_tol = tol;
    ref_div_i    = DIV_W'(rdiv);
    fb_div_i     = DIV_W'(fdiv);
    win_max_i    = CNT_W'(wmax);
    cnt_offset_i = CNT_W'(ofs);
    match_tol_i  = CNT_W'(tol);
    m_rpre = 0; m_fpre = 0; m_rcnt = 0; m_fcnt = 0;
    exp_diff = 0; exp_match = 1'b0; exp_loss = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    // idle while the internal reset release propagates
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare("R1 idle");
    end
  endtask

  // rper/fper: pulse period in cycles (0 = none); rnd selects pseudo-random pulses
  task automatic run(string tag, int n, int rper, int fper, bit rnd);
    bit rp, fp;
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        rp = lfsr[0];
        fp = lfsr[3] | lfsr[5];
      end else begin
        rp = (rper != 0) && (i % rper == 0);
        fp = (fper != 0) && (i % fper == 0);
      end
      ref_pulse_i = rp;
      fb_pulse_i  = fp;
      model_step(rp, fp);
      @(negedge clk);
      compare(tag);
    end
    ref_pulse_i = 1'b0;
    fb_pulse_i  = 1'b0;
  endtask

  initial begin
    lfsr = 32'h0000ACE1;
    rst_n = 1'b0;
    ref_pulse_i = 1'b0;
    fb_pulse_i  = 1'b0;

    // R6: equal rates, no bias -> zero difference, match, no loss
    start(1, 1, 20, 0, 2);
    run("R6 equal", 400, 2, 2, 1'b0);

    // R2 R3: equal rates only after pre-division, feedback divider 0 acts as 1
    start(3, 0, 8, 0, 1);
    run("R2 R3 divided", 500, 1, 3, 1'b0);

    // R7: feedback twice the reference rate -> large positive difference, loss
    start(1, 1, 10, 0, 2);
    run("R7 fast fb", 300, 2, 1, 1'b0);

    // R4: window length 0 acts as 1, negative bias
    start(1, 1, 0, -1, 2);
    run("R4 one-pulse window", 200, 4, 4, 1'b0);

    // R6 boundary: magnitude equal to tolerance gives no match
    start(1, 1, 20, 2, 2);
    run("R6 tol edge", 300, 2, 2, 1'b0);

    // R8: random pulses land on closing cycles
    start(2, 1, 50, 3, 5);
    run("R8 random", 3000, 0, 0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule